// File: doc/BRIEF.md
# Integer to Half-Precision Float Converter

This block turns a 16-bit sign-magnitude integer into a 16-bit half-precision floating-point word. The top bit of the operand is the sign and goes straight to the top bit of the result. The remaining 15 bits are an unsigned magnitude. The magnitude is normalized so that its leading one reaches the top magnitude position. The normalizer uses a shift register that moves one bit per clock while an exponent counter counts down. The hidden leading one is then dropped, and the fraction is rounded to nearest-even in one extra cycle.

An operand is taken with a valid/ready handshake. The block raises `in_ready` only when it is idle. While a conversion is in flight `in_ready` stays low, and any `in_valid` during that time is left unaccepted and has no effect. Holding the data and waiting for `in_ready` is the upstream side's job. The result side has no back-pressure. `out_valid` rises when the result is final, and `out_valid` and `out_data` stay unchanged until the next operand is accepted. In the cycle after that acceptance, `out_valid` drops.

Top module: `int2half`

## Requirements
- R1: Result bit 15 equals bit 15 of the accepted operand.
- R2: For a non-zero magnitude whose leading one is at bit k, the exponent in result bits 14:10 is 15+k before rounding. The fraction sits in bits 9:0, and the leading one is not stored.
- R3: A zero magnitude gives exponent 0 and fraction 0.
- R4: When k is 10 or less, the fraction is the bits below the leading one, left-aligned and zero-padded, with no rounding.
- R5: When k is above 10, the 11-bit significand is the leading one and the next 10 bits. The bit below it is the round bit, and the OR of all lower bits is the sticky bit. The round bit is added only if the significand LSB or the sticky bit is set, which gives round-half-to-even.
- R6: A rounding carry out of the 11-bit significand increments the exponent and leaves a zero fraction, so magnitude 0x7FFF gives 0x7800.
- R7: `in_ready` is high only while idle. `in_valid` while `in_ready` is low is not accepted and does not change the result.
- R8: `out_valid` rises exactly 16-k clock edges after the accepting edge, or 2 edges for a zero magnitude. It drops on the edge after an acceptance, and while high it holds with `out_data` stable.
- R9: After reset, `in_ready` is 1, `out_valid` is 0 and `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present on `in_data` |
| in_ready | output | 1 | Block idle and able to take an operand |
| in_data | input | 16 | Sign-magnitude operand, sign in bit 15 |
| out_valid | output | 1 | Result valid, held until the next acceptance |
| out_data | output | 16 | Sign, 5-bit biased exponent, 10-bit fraction |

## Verification
The bench builds the block with its default parameters: 16-bit words, a 5-bit exponent, a 10-bit fraction and a bias of 15. This puts every leading-one position from bit 0 to bit 14 within reach, including the exact range, the rounding range and the all-ones magnitude that carries into exponent 30. Random magnitudes are shifted right by random amounts so that every latency from 2 to 16 edges occurs. Both signs are used. Busy periods are flooded with junk `in_valid` requests, and the handshake timing is checked edge by edge.

// File: rtl/int2half_pkg.sv
package int2half_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_NORM  = 2'd1,
    ST_ROUND = 2'd2
  } cvt_state_e;
endpackage

// File: rtl/int2half_norm.sv
module int2half_norm #(
  parameter int MAG_W = 15,
  parameter int EXP_W = 5,
  parameter int BIAS  = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [MAG_W-1:0] load_mag,
  input  logic             shift_en,
  output logic [MAG_W-1:0] mag_q,
  output logic [EXP_W-1:0] exp_q,
  output logic             top_set,
  output logic             is_zero
);
  localparam logic [EXP_W-1:0] EXP_TOP = EXP_W'(BIAS + MAG_W - 1);

  assign top_set = mag_q[MAG_W-1];
  assign is_zero = (mag_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q <= '0;
      exp_q <= '0;
    end else if (load) begin
      mag_q <= load_mag;
      exp_q <= EXP_TOP;
    end else if (shift_en && !top_set && !is_zero) begin
      mag_q <= mag_q << 1;
      exp_q <= exp_q - 1'b1;
    end
  end

  // R2: each normalizing step lowers the exponent by one
  a_r2_shift_step: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !load && !top_set && !is_zero) |=> (exp_q == $past(exp_q) - 1'b1))
    else $error("a_r2_shift_step");

  // R2: the magnitude is never lost while normalizing
  a_r2_mag_kept: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !load && !is_zero) |=> !is_zero)
    else $error("a_r2_mag_kept");
endmodule

// File: rtl/int2half_round.sv
module int2half_round #(
  parameter int MAG_W  = 15,
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10
) (
  input  logic [MAG_W-1:0]  mag,
  input  logic [EXP_W-1:0]  exp_in,
  input  logic              zero,
  output logic [EXP_W-1:0]  exp_out,
  output logic [FRAC_W-1:0] frac_out
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int LOW_W = MAG_W - SIG_W;

  logic [SIG_W-1:0] sig;
  logic             rnd_bit;
  logic             sticky;
  logic             inc;
  logic [SIG_W:0]   sum;

  assign sig     = mag[MAG_W-1 -: SIG_W];
  assign rnd_bit = mag[LOW_W-1];

  generate
    if (LOW_W > 1) begin : g_sticky
      assign sticky = |mag[LOW_W-2:0];
    end else begin : g_no_sticky
      assign sticky = 1'b0;
    end
  endgenerate

  assign inc = rnd_bit & (sig[0] | sticky);
  assign sum = {1'b0, sig} + {{SIG_W{1'b0}}, inc};

  always_comb begin
    if (zero) begin
      exp_out  = '0;
      frac_out = '0;
    end else if (sum[SIG_W]) begin
      exp_out  = exp_in + 1'b1;
      frac_out = sum[FRAC_W:1];
    end else begin
      exp_out  = exp_in;
      frac_out = sum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/int2half.sv
module int2half #(
  parameter int WIDTH  = 16,
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10,
  parameter int BIAS   = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data
);
  import int2half_pkg::*;

  localparam int MAG_W = WIDTH - 1;

  cvt_state_e        state_q;
  logic              sign_q;
  logic              accept;
  logic [MAG_W-1:0]  mag_q;
  logic [EXP_W-1:0]  exp_q;
  logic              top_set;
  logic              is_zero;
  logic [EXP_W-1:0]  exp_r;
  logic [FRAC_W-1:0] frac_r;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;

  int2half_norm #(.MAG_W(MAG_W), .EXP_W(EXP_W), .BIAS(BIAS)) u_norm (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_mag (in_data[MAG_W-1:0]),
    .shift_en (state_q == ST_NORM),
    .mag_q    (mag_q),
    .exp_q    (exp_q),
    .top_set  (top_set),
    .is_zero  (is_zero)
  );

  int2half_round #(.MAG_W(MAG_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .mag      (mag_q),
    .exp_in   (exp_q),
    .zero     (is_zero),
    .exp_out  (exp_r),
    .frac_out (frac_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sign_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_NORM;
          sign_q  <= in_data[WIDTH-1];
        end
        ST_NORM:  if (top_set || is_zero) state_q <= ST_ROUND;
        ST_ROUND: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b0;
    end else if (state_q == ST_ROUND) begin
      out_valid <= 1'b1;
      out_data  <= {sign_q, exp_r, frac_r};
    end
  end

  // R7: an accepted operand makes the block busy and clears the result flag
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!in_ready && !out_valid))
    else $error("a_r7_busy_after_accept");

  // R8: a valid result holds until the next acceptance
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !accept) |=> (out_valid && $stable(out_data)))
    else $error("a_r8_hold");

  // R3: a zero exponent always carries a zero fraction
  a_r3_zero_frac: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_data[WIDTH-2 -: EXP_W] == '0) |-> (out_data[FRAC_W-1:0] == '0))
    else $error("a_r3_zero_frac");

  // R2: a non-zero exponent stays within the reachable range
  a_r2_exp_range: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_data[WIDTH-2 -: EXP_W] != '0) |->
      (int'(out_data[WIDTH-2 -: EXP_W]) >= BIAS &&
       int'(out_data[WIDTH-2 -: EXP_W]) <= BIAS + MAG_W))
    else $error("a_r2_exp_range");
endmodule

// File: tb/test_int2half.sv
module test_int2half;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [15:0] out_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done_flag = 0;

  // model state
  bit          m_ready = 1;
  bit          m_valid = 0;
  bit          m_new = 0;
  logic [15:0] m_out = '0;
  logic [15:0] m_pend = '0;
  bit          m_sign = 0;
  int          m_cnt = 0;
  string       m_tag = "R2";
  string       m_ptag = "R2";

  int2half i_int2half (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  always #5ns clk = ~clk;

  function automatic int lead_pos(input int mag);
    int k = -1;
    for (int i = 0; i < 15; i++) if (((mag >> i) & 1) == 1) k = i;
    return k;
  endfunction

  function automatic logic [15:0] ref_conv(input logic [15:0] x);
    int mag = int'(x[14:0]);
    int k = lead_pos(mag);
    int e, q, rem, half, sh;
    if (k < 0) return {x[15], 15'd0};
    e = 15 + k;
    if (k <= 10) begin
      q = (mag - (1 << k)) << (10 - k);
    end else begin
      sh = k - 10;
      q = mag >> sh;
      rem = mag - (q << sh);
      half = 1 << (sh - 1);
      if (rem > half || (rem == half && (q % 2) == 1)) q = q + 1;
      if (q == 2048) begin q = 1024; e = e + 1; end
      q = q - 1024;
    end
    return {x[15], 5'(e), 10'(q)};
  endfunction

  function automatic string cat_tag(input logic [15:0] x);
    int mag = int'(x[14:0]);
    int k = lead_pos(mag);
    logic [15:0] r = ref_conv(x);
    if (k < 0) return "R3";
    if (k <= 10) return "R4";
    if (int'(r[14:10]) != 15 + k) return "R6";
    return "R5";
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // cycle-level reference model
  always @(posedge clk) begin
    cyc++;
    m_new = 0;
    if (rst) begin
      m_ready = 1; m_valid = 0; m_out = '0; m_cnt = 0;
    end else if (m_ready && in_valid) begin
      m_pend = ref_conv(in_data);
      m_sign = in_data[15];
      m_ptag = cat_tag(in_data);
      m_cnt  = (in_data[14:0] == 0) ? 2 : 16 - lead_pos(int'(in_data[14:0]));
      m_ready = 0; m_valid = 0;
    end else if (!m_ready) begin
      m_cnt--;
      if (m_cnt == 0) begin
        m_valid = 1; m_out = m_pend; m_ready = 1; m_new = 1; m_tag = m_ptag;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      check(in_ready === m_ready, "R7 in_ready", 16'(in_ready), 16'(m_ready));
      check(out_valid === m_valid, "R8 out_valid", 16'(out_valid), 16'(m_valid));
      check(out_data === m_out, {m_tag, " out_data"}, out_data, m_out);
      if (m_new) check(out_data[15] === m_sign, "R1 sign", 16'(out_data[15]), 16'(m_sign));
    end
  end

  task automatic send(input logic [15:0] x, input bit junk);
    @(negedge clk);
    while (!m_ready) @(negedge clk);
    in_valid = 1; in_data = x;
    @(negedge clk);
    if (junk) begin
      while (!m_valid) begin
        in_data = 16'($urandom); in_valid = 1;
        @(negedge clk);
      end
    end
    in_valid = 0;
    while (!m_valid) @(negedge clk);
  endtask

  initial begin : watchdog
    while (cyc < 150000 && !done_flag) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] fixed [14];
    fixed = '{16'd0, 16'd1, 16'd2, 16'd3, 16'd12, 16'd48, 16'd8191, 16'd16383,
              16'd30767, 16'd32767, 16'h0801, 16'h0803, 16'h0805, 16'h1002};
    repeat (3) @(negedge clk);
    // R9: reset values
    check(in_ready === 1'b1, "R9 in_ready", 16'(in_ready), 16'd1);
    check(out_valid === 1'b0, "R9 out_valid", 16'(out_valid), 16'd0);
    check(out_data === 16'd0, "R9 out_data", out_data, 16'd0);
    rst = 0;
    foreach (fixed[i]) begin
      send(fixed[i], 0);
      send({1'b1, fixed[i][14:0]}, 1);
    end
    // R6: all-ones magnitude
    send(16'h7FFF, 0);
    @(negedge clk);
    check(out_data === 16'h7800, "R6 all ones", out_data, 16'h7800);
    for (int n = 0; n < 300; n++) begin
      logic [15:0] x = 16'($urandom);
      int sh = $urandom % 16;
      x[14:0] = x[14:0] >> sh;
      send(x, (n % 3) == 0);
      if (n % 5 == 0) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule